// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Shared Timebases

The block produces eight pulse-width-modulated outputs from a small pool of three shared timebases. Each timebase is a two-stage divider: a 16-bit prescaler counts source ticks, and each time it wraps, an 8-bit cycle counter advances. One full cycle-counter sweep is one output period. Every timebase takes its ticks from one of two clock-enable strobes. One is a fast source. The other is a slow source that stands in for a 32.768 kHz clock which stays alive in low-power states.

Each channel chooses a timebase and compares that timebase's cycle count against its own duty value. It then applies polarity, gating and an optional open-drain drive mode. The block has no separate pin output. It presents a logic level and a drive enable for each channel, and pad logic outside the block combines the two.

All configuration arrives over a byte-wide write port with a 5-bit address. A new prescaler, cycle or duty value does not take effect immediately. It is held until the end of the running period, so an update never cuts a pulse short.

Top module: `mpwm_bank`

## Requirements
- R1: Timebase t (t = 0..2) has its prescaler low byte at address 0x08+3t, its prescaler high byte at 0x09+3t and its cycle value at 0x0A+3t. With prescaler P and cycle value C, its output period is (P+1)×(C+1) source ticks.
- R2: Before polarity, a channel is active while its timebase's cycle count is below the channel's duty value. The duty value for channel n is at address 0x18+n. An active pulse therefore lasts duty×(P+1) ticks. A duty of 0 keeps the channel inactive for the whole period, and a duty above C keeps it active for the whole period.
- R3: Bit n of address 0x03 inverts channel n's output level when set.
- R4: Bit n of address 0x02 set stops channel n and holds its level at the inactive value, which equals its polarity bit. After reset this register is all ones.
- R5: Address 0x05 holds the timebase selects for channels 0-3 and address 0x06 holds them for channels 4-7. Channel n uses bits [(n mod 4)×2 +: 2]. A select value of 3 names no timebase and holds the channel inactive.
- R6: Bit t of address 0x01 set clocks timebase t from the fast strobe `tick_fast`. Cleared, it clocks the timebase from the slow strobe `tick_slow`.
- R7: Bit 0 of address 0x00 is the global counter enable. While it is clear, no timebase advances and every output holds its level.
- R8: A prescaler, cycle or duty write made during a period takes effect only when that period ends. The pulse and period that are running complete with their old values.
- R9: Bit n of address 0x04 set puts channel n in open-drain mode. In that mode `pwm_drive_en[n]` is high exactly when the level is low. With the bit clear, the drive enable is always high.
- R10: After reset every output level is 0 and every drive enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Fast source clock-enable strobe |
| tick_slow | input | 1 | Slow source clock-enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_level | output | 8 | Per-channel output logic level |
| pwm_drive_en | output | 8 | Per-channel pad drive enable |

## Verification
The bench goes after the period and pulse arithmetic, checking both the low and high prescaler bytes. A design that dropped the "+1" on either divider, or ignored the high byte, would measure a period that is short by whole prescaler steps. The duty corners are 0 and a value above the cycle limit. An off-by-one compare would leak a one-tick glitch at duty 0 or open a gap when the duty exceeds the cycle limit.

Select values are packed four to a byte. Misplaced bit slicing would route channel 5 to the wrong timebase, and a select of 3 that was not decoded would alias onto a real timebase. A mid-pulse duty write and a mid-period cycle write must leave the running pulse at its old width. A design that loads these values immediately would truncate that pulse and shorten that period.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

   localparam int unsigned REG_ADDR_W = 5;
   localparam int unsigned REG_DATA_W = 8;
   localparam int unsigned SEL_W      = 2;

   // Single-byte control registers
   localparam logic [REG_ADDR_W-1:0] ADR_CTRL = 5'h00;
   localparam logic [REG_ADDR_W-1:0] ADR_SRC  = 5'h01;
   localparam logic [REG_ADDR_W-1:0] ADR_GATE = 5'h02;
   localparam logic [REG_ADDR_W-1:0] ADR_POL  = 5'h03;
   localparam logic [REG_ADDR_W-1:0] ADR_ODEN = 5'h04;
   localparam logic [REG_ADDR_W-1:0] ADR_SEL0 = 5'h05;
   localparam logic [REG_ADDR_W-1:0] ADR_SEL1 = 5'h06;

   // Repeated register groups
   localparam int TB_BASE   = 8;
   localparam int TB_STRIDE = 3;
   localparam int DUTY_BASE = 24;

   // Channels whose select fields share one byte
   localparam int SEL_PER_BYTE = REG_DATA_W / SEL_W;

endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs
   import mpwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned NUM_TB = 3,
   parameter int unsigned PRE_W  = 16,
   parameter int unsigned CYC_W  = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [REG_ADDR_W-1:0]             wr_addr,
   input  logic [REG_DATA_W-1:0]             wr_data,
   output logic                              glb_en,
   output logic [NUM_TB-1:0]                 tb_fast,
   output logic [NUM_TB-1:0][PRE_W-1:0]      tb_pre,
   output logic [NUM_TB-1:0][CYC_W-1:0]      tb_cyc,
   output logic [NUM_CH-1:0]                 ch_gate,
   output logic [NUM_CH-1:0]                 ch_pol,
   output logic [NUM_CH-1:0]                 ch_od,
   output logic [NUM_CH-1:0][SEL_W-1:0]      ch_sel,
   output logic [NUM_CH-1:0][CYC_W-1:0]      ch_duty
);

   localparam int unsigned SEL_BYTES = (NUM_CH + SEL_PER_BYTE - 1) / SEL_PER_BYTE;
   localparam int unsigned PRE_HI_W  = PRE_W - REG_DATA_W;

   logic                                 en_q;
   logic [NUM_TB-1:0]                    src_q;
   logic [NUM_CH-1:0]                    gate_q;
   logic [NUM_CH-1:0]                    pol_q;
   logic [NUM_CH-1:0]                    od_q;
   logic [1:0][REG_DATA_W-1:0]           sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         src_q  <= '0;
         gate_q <= '1;
         pol_q  <= '0;
         od_q   <= '0;
         sel_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_CTRL: en_q     <= wr_data[0];
            ADR_SRC:  src_q    <= wr_data[NUM_TB-1:0];
            ADR_GATE: gate_q   <= wr_data[NUM_CH-1:0];
            ADR_POL:  pol_q    <= wr_data[NUM_CH-1:0];
            ADR_ODEN: od_q     <= wr_data[NUM_CH-1:0];
            ADR_SEL0: sel_q[0] <= wr_data;
            ADR_SEL1: sel_q[1] <= wr_data;
            default:  ;
         endcase
      end
   end

   assign glb_en  = en_q;
   assign tb_fast = src_q;
   assign ch_gate = gate_q;
   assign ch_pol  = pol_q;
   assign ch_od   = od_q;

   // Per-timebase divider registers
   for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
      localparam int ADR_I = TB_BASE + TB_STRIDE * t;
      localparam logic [REG_ADDR_W-1:0] ADR_LO  = REG_ADDR_W'(ADR_I);
      localparam logic [REG_ADDR_W-1:0] ADR_HI  = REG_ADDR_W'(ADR_I + 1);
      localparam logic [REG_ADDR_W-1:0] ADR_CYC = REG_ADDR_W'(ADR_I + 2);

      logic [PRE_W-1:0] pre_q;
      logic [CYC_W-1:0] cyc_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
            cyc_q <= '0;
         end else if (wr_en) begin
            if (wr_addr == ADR_LO)
               pre_q[REG_DATA_W-1:0] <= wr_data;
            if (wr_addr == ADR_HI)
               pre_q[PRE_W-1:REG_DATA_W] <= wr_data[PRE_HI_W-1:0];
            if (wr_addr == ADR_CYC)
               cyc_q <= wr_data[CYC_W-1:0];
         end
      end

      assign tb_pre[t] = pre_q;
      assign tb_cyc[t] = cyc_q;
   end

   // Per-channel duty registers and packed select extraction
   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam logic [REG_ADDR_W-1:0] ADR_DUTY = REG_ADDR_W'(DUTY_BASE + n);
      localparam int SEL_BYTE = n / SEL_PER_BYTE;
      localparam int SEL_LSB  = (n % SEL_PER_BYTE) * SEL_W;

      logic [CYC_W-1:0] duty_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            duty_q <= '0;
         else if (wr_en && wr_addr == ADR_DUTY)
            duty_q <= wr_data[CYC_W-1:0];
      end

      assign ch_duty[n] = duty_q;
      assign ch_sel[n]  = sel_q[SEL_BYTE][SEL_LSB +: SEL_W];
   end

   if (SEL_BYTES > 2) begin : g_bad_sel
      $error("mpwm_regs: select storage covers at most two bytes");
   end

endmodule

// File: rtl/mpwm_timebase.sv
module mpwm_timebase #(
   parameter int unsigned PRE_W = 16,
   parameter int unsigned CYC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick_fast,
   input  logic             tick_slow,
   input  logic             use_fast,
   input  logic [PRE_W-1:0] pre_cfg,
   input  logic [CYC_W-1:0] cyc_cfg,
   output logic [CYC_W-1:0] cyc_cnt,
   output logic             period_end
);

   logic [PRE_W-1:0] pre_act;
   logic [CYC_W-1:0] cyc_act;
   logic [PRE_W-1:0] pre_cnt;
   logic [CYC_W-1:0] cyc_q;
   logic             tick;
   logic             pre_wrap;
   logic             cyc_wrap;

   assign tick       = run & (use_fast ? tick_fast : tick_slow);
   assign pre_wrap   = (pre_cnt == pre_act);
   assign cyc_wrap   = (cyc_q == cyc_act);
   assign period_end = tick & pre_wrap & cyc_wrap;
   assign cyc_cnt    = cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_act <= '0;
         cyc_act <= '0;
         pre_cnt <= '0;
         cyc_q   <= '0;
      end else if (tick) begin
         if (!pre_wrap) begin
            pre_cnt <= pre_cnt + PRE_W'(1);
         end else begin
            pre_cnt <= '0;
            if (!cyc_wrap) begin
               cyc_q <= cyc_q + CYC_W'(1);
            end else begin
               cyc_q   <= '0;
               pre_act <= pre_cfg;
               cyc_act <= cyc_cfg;
            end
         end
      end
   end

endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel
   import mpwm_pkg::*;
#(
   parameter int unsigned NUM_TB = 3,
   parameter int unsigned CYC_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SEL_W-1:0]              sel,
   input  logic [NUM_TB-1:0][CYC_W-1:0]  tb_cnt,
   input  logic [NUM_TB-1:0]             tb_end,
   input  logic [CYC_W-1:0]              duty_cfg,
   input  logic                          gate,
   input  logic                          pol,
   input  logic                          od,
   output logic                          level,
   output logic                          drive_en
);

   logic [CYC_W-1:0] my_cnt;
   logic             my_end;
   logic             sel_ok;
   logic [CYC_W-1:0] duty_act;
   logic             raw;

   always_comb begin
      my_cnt = '0;
      my_end = 1'b0;
      sel_ok = 1'b0;
      for (int t = 0; t < NUM_TB; t++) begin
         if (sel == SEL_W'(t)) begin
            my_cnt = tb_cnt[t];
            my_end = tb_end[t];
            sel_ok = 1'b1;
         end
      end
   end

   // Duty is taken over only at the selected timebase's period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         duty_act <= '0;
      else if (my_end || !sel_ok)
         duty_act <= duty_cfg;
   end

   assign raw      = sel_ok & ~gate & (my_cnt < duty_act);
   assign level    = raw ^ pol;
   assign drive_en = od ? ~level : 1'b1;

endmodule

// File: rtl/mpwm_bank.sv
module mpwm_bank
   import mpwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned NUM_TB = 3,
   parameter int unsigned PRE_W  = 16,
   parameter int unsigned CYC_W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick_fast,
   input  logic                   tick_slow,
   input  logic                   wr_en,
   input  logic [REG_ADDR_W-1:0]  wr_addr,
   input  logic [REG_DATA_W-1:0]  wr_data,
   output logic [NUM_CH-1:0]      pwm_level,
   output logic [NUM_CH-1:0]      pwm_drive_en
);

   if (NUM_CH < 1 || NUM_CH > REG_DATA_W) begin : g_bad_ch
      $error("mpwm_bank: NUM_CH must lie in 1..8");
   end
   if (NUM_TB < 1 || NUM_TB > (1 << SEL_W) - 1) begin : g_bad_tb
      $error("mpwm_bank: NUM_TB must leave one select code unused");
   end
   if (PRE_W <= REG_DATA_W || PRE_W > 2 * REG_DATA_W) begin : g_bad_pre
      $error("mpwm_bank: PRE_W must span two register bytes");
   end
   if (CYC_W < 1 || CYC_W > REG_DATA_W) begin : g_bad_cyc
      $error("mpwm_bank: CYC_W must fit one register byte");
   end

   logic                             glb_en;
   logic [NUM_TB-1:0]                tb_fast;
   logic [NUM_TB-1:0][PRE_W-1:0]     tb_pre;
   logic [NUM_TB-1:0][CYC_W-1:0]     tb_cyc;
   logic [NUM_CH-1:0]                ch_gate;
   logic [NUM_CH-1:0]                ch_pol;
   logic [NUM_CH-1:0]                ch_od;
   logic [NUM_CH-1:0][SEL_W-1:0]     ch_sel;
   logic [NUM_CH-1:0][CYC_W-1:0]     ch_duty;
   logic [NUM_TB-1:0][CYC_W-1:0]     tb_cnt;
   logic [NUM_TB-1:0]                tb_end;

   mpwm_regs #(
      .NUM_CH (NUM_CH),
      .NUM_TB (NUM_TB),
      .PRE_W  (PRE_W),
      .CYC_W  (CYC_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .glb_en  (glb_en),
      .tb_fast (tb_fast),
      .tb_pre  (tb_pre),
      .tb_cyc  (tb_cyc),
      .ch_gate (ch_gate),
      .ch_pol  (ch_pol),
      .ch_od   (ch_od),
      .ch_sel  (ch_sel),
      .ch_duty (ch_duty)
   );

   for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
      mpwm_timebase #(
         .PRE_W (PRE_W),
         .CYC_W (CYC_W)
      ) u_tb (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (glb_en),
         .tick_fast  (tick_fast),
         .tick_slow  (tick_slow),
         .use_fast   (tb_fast[t]),
         .pre_cfg    (tb_pre[t]),
         .cyc_cfg    (tb_cyc[t]),
         .cyc_cnt    (tb_cnt[t]),
         .period_end (tb_end[t])
      );
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      mpwm_channel #(
         .NUM_TB (NUM_TB),
         .CYC_W  (CYC_W)
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (ch_sel[n]),
         .tb_cnt   (tb_cnt),
         .tb_end   (tb_end),
         .duty_cfg (ch_duty[n]),
         .gate     (ch_gate[n]),
         .pol      (ch_pol[n]),
         .od       (ch_od[n]),
         .level    (pwm_level[n]),
         .drive_en (pwm_drive_en[n])
      );
   end

endmodule

// File: rtl/mpwm_bank_chk.sv
module mpwm_bank_chk #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned NUM_TB = 3,
   parameter int unsigned CYC_W  = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          glb_en,
   input logic [NUM_TB-1:0][CYC_W-1:0]  tb_cnt,
   input logic [NUM_TB-1:0]             tb_end,
   input logic [NUM_CH-1:0]             ch_gate,
   input logic [NUM_CH-1:0]             ch_pol,
   input logic [NUM_CH-1:0]             ch_od,
   input logic [NUM_CH-1:0][1:0]        ch_sel,
   input logic [NUM_CH-1:0]             pwm_level,
   input logic [NUM_CH-1:0]             pwm_drive_en
);

   for (genvar t = 0; t < NUM_TB; t++) begin : g_tb_chk
      // R7
      frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !glb_en |=> $stable(tb_cnt[t]));
      // R1
      restart_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tb_end[t] |=> tb_cnt[t] == '0);
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch_chk
      // R4
      gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_gate[n] |-> pwm_level[n] == ch_pol[n]);
      // R5
      bad_select_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(ch_sel[n]) >= NUM_TB) |-> pwm_level[n] == ch_pol[n]);
      // R9
      od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_od[n] |-> pwm_drive_en[n] == !pwm_level[n]);
      // R9
      push_pull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_od[n] |-> pwm_drive_en[n]);
   end

endmodule

bind mpwm_bank mpwm_bank_chk #(
   .NUM_CH (NUM_CH),
   .NUM_TB (NUM_TB),
   .CYC_W  (CYC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .glb_en       (glb_en),
   .tb_cnt       (tb_cnt),
   .tb_end       (tb_end),
   .ch_gate      (ch_gate),
   .ch_pol       (ch_pol),
   .ch_od        (ch_od),
   .ch_sel       (ch_sel),
   .pwm_level    (pwm_level),
   .pwm_drive_en (pwm_drive_en)
);

// File: tb/mpwm_bank_test.sv
`timescale 1ns/1ps
module mpwm_bank_test;

   localparam logic [4:0] A_CTRL = 5'h00, A_SRC = 5'h01, A_GATE = 5'h02, A_POL = 5'h03;
   localparam logic [4:0] A_OD = 5'h04, A_SEL0 = 5'h05, A_SEL1 = 5'h06;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_fast = 1'b1;
   logic       tick_slow = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] pwm_level;
   logic [7:0] pwm_drive_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   mpwm_bank uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_fast    (tick_fast),
      .tick_slow    (tick_slow),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .pwm_level    (pwm_level),
      .pwm_drive_en (pwm_drive_en)
   );

   always #10 clk = ~clk;

   // Slow strobe: one pulse every fourth clock
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         div = (div + 1) % 4;
         tick_slow = (div == 0);
      end
   end

   task automatic check_eq(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic set_tb(input int t, input int pre, input int cyc);
      wr(5'(8 + 3 * t), 8'(pre & 255));
      wr(5'(9 + 3 * t), 8'((pre >> 8) & 255));
      wr(5'(10 + 3 * t), 8'(cyc));
   endtask

   task automatic set_duty(input int ch, input int d);
      wr(5'(24 + ch), 8'(d));
   endtask

   // Active time and period of one full cycle, sampled on falling edges
   task automatic measure(input int ch, input bit inv, output int hi, output int per);
      int g = 0;
      hi = 0;
      per = 0;
      while ((pwm_level[ch] ^ inv) !== 1'b0 && g < 20000) begin @(negedge clk); g++; end
      while ((pwm_level[ch] ^ inv) !== 1'b1 && g < 20000) begin @(negedge clk); g++; end
      while ((pwm_level[ch] ^ inv) === 1'b1 && g < 20000) begin hi++; per++; @(negedge clk); g++; end
      while ((pwm_level[ch] ^ inv) === 1'b0 && g < 20000) begin per++; @(negedge clk); g++; end
   endtask

   task automatic count_high(input int ch, input int n, output int ones);
      ones = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_level[ch] === 1'b1) ones++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      do_reset();
      check_eq("R10 level after reset", int'(pwm_level), 0);
      check_eq("R10 drive enable after reset", int'(pwm_drive_en), 255);
   endtask

   task automatic t_period();
      int hi, per;
      do_reset();
      wr(A_SRC, 8'h07);
      set_tb(0, 1, 9);
      set_tb(1, 4, 3);
      set_tb(2, 258, 1);
      wr(A_SEL0, 8'h24);
      set_duty(0, 3);
      set_duty(1, 2);
      set_duty(2, 1);
      wr(A_GATE, 8'hF8);
      wr(A_CTRL, 8'h01);
      measure(0, 1'b0, hi, per);
      check_eq("R1 period tb0", per, 20);
      check_eq("R2 pulse tb0", hi, 6);
      measure(1, 1'b0, hi, per);
      check_eq("R1 period tb1", per, 20);
      check_eq("R2 pulse tb1", hi, 10);
      measure(2, 1'b0, hi, per);
      check_eq("R1 period with high prescaler byte", per, 518);
      check_eq("R2 pulse with high prescaler byte", hi, 259);
   endtask

   task automatic t_duty_edges();
      int ones;
      do_reset();
      wr(A_SRC, 8'h07);
      set_tb(0, 1, 9);
      set_duty(3, 0);
      set_duty(4, 200);
      wr(A_GATE, 8'h00);
      wr(A_CTRL, 8'h01);
      repeat (25) @(negedge clk);
      count_high(3, 60, ones);
      check_eq("R2 duty zero stays inactive", ones, 0);
      count_high(4, 60, ones);
      check_eq("R2 duty above cycle stays active", ones, 60);
   endtask

   task automatic t_polarity();
      int hi, per;
      do_reset();
      wr(A_SRC, 8'h07);
      set_tb(0, 1, 9);
      set_duty(0, 3);
      wr(A_POL, 8'h01);
      wr(A_GATE, 8'hFE);
      wr(A_CTRL, 8'h01);
      measure(0, 1'b1, hi, per);
      check_eq("R3 inverted low time", hi, 6);
      check_eq("R3 inverted period", per, 20);
   endtask

   task automatic t_gating();
      int ones, hi, per;
      do_reset();
      wr(A_SRC, 8'h07);
      set_tb(0, 1, 9);
      set_duty(0, 3);
      wr(A_CTRL, 8'h01);
      count_high(0, 60, ones);
      check_eq("R4 reset gating holds channel", ones, 0);
      wr(A_GATE, 8'hFE);
      measure(0, 1'b0, hi, per);
      check_eq("R4 ungated channel runs", per, 20);
      wr(A_POL, 8'h01);
      wr(A_GATE, 8'h01);
      count_high(0, 60, ones);
      check_eq("R4 gated level equals polarity", ones, 60);
   endtask

   task automatic t_select();
      int ones, hi, per;
      do_reset();
      wr(A_SRC, 8'h07);
      set_tb(0, 1, 9);
      set_tb(2, 2, 4);
      set_duty(5, 2);
      wr(A_SEL1, 8'h08);
      wr(A_GATE, 8'h00);
      wr(A_CTRL, 8'h01);
      measure(5, 1'b0, hi, per);
      check_eq("R5 channel 5 follows tb2 period", per, 15);
      check_eq("R5 channel 5 follows tb2 pulse", hi, 6);
      wr(A_SEL1, 8'h0C);
      count_high(5, 60, ones);
      check_eq("R5 select 3 holds inactive", ones, 0);
   endtask

   task automatic t_source();
      int hi, per;
      do_reset();
      wr(A_SRC, 8'h05);
      set_tb(1, 1, 4);
      wr(A_SEL0, 8'h04);
      set_duty(1, 2);
      wr(A_GATE, 8'h00);
      wr(A_CTRL, 8'h01);
      measure(1, 1'b0, hi, per);
      check_eq("R6 slow source period", per, 40);
      check_eq("R6 slow source pulse", hi, 16);
   endtask

   task automatic t_enable();
      int hi, per, changes;
      logic snap;
      do_reset();
      wr(A_SRC, 8'h07);
      set_tb(0, 1, 9);
      set_duty(0, 5);
      wr(A_GATE, 8'h00);
      wr(A_CTRL, 8'h01);
      repeat (33) @(negedge clk);
      wr(A_CTRL, 8'h00);
      snap = pwm_level[0];
      changes = 0;
      for (int i = 0; i < 60; i++) begin
         if (pwm_level[0] !== snap) changes++;
         @(negedge clk);
      end
      check_eq("R7 disabled output holds", changes, 0);
      wr(A_CTRL, 8'h01);
      measure(0, 1'b0, hi, per);
      check_eq("R7 re-enabled period", per, 20);
   endtask

   task automatic t_latch();
      int hi, per, g;
      do_reset();
      wr(A_SRC, 8'h07);
      set_tb(0, 9, 9);
      set_duty(0, 5);
      wr(A_GATE, 8'h00);
      wr(A_CTRL, 8'h01);
      g = 0;
      hi = 0;
      per = 0;
      while (pwm_level[0] !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
      while (pwm_level[0] !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
      while (pwm_level[0] === 1'b1 && g < 5000) begin
         wr_en = 1'b0;
         if (hi == 10) begin wr_en = 1'b1; wr_addr = 5'h18; wr_data = 8'd2; end
         if (hi == 11) begin wr_en = 1'b1; wr_addr = 5'h0A; wr_data = 8'd4; end
         hi++;
         per++;
         @(negedge clk);
         g++;
      end
      wr_en = 1'b0;
      while (pwm_level[0] === 1'b0 && g < 5000) begin per++; @(negedge clk); g++; end
      check_eq("R8 running pulse keeps old duty", hi, 50);
      check_eq("R8 running period keeps old cycle", per, 100);
      measure(0, 1'b0, hi, per);
      check_eq("R8 next pulse uses new duty", hi, 20);
      check_eq("R8 next period uses new cycle", per, 50);
   endtask

   task automatic t_open_drain();
      int bad, seen_hi, seen_lo, pp_bad;
      do_reset();
      wr(A_SRC, 8'h07);
      set_tb(0, 1, 9);
      set_duty(0, 4);
      set_duty(1, 4);
      wr(A_OD, 8'h01);
      wr(A_GATE, 8'h00);
      wr(A_CTRL, 8'h01);
      bad = 0; seen_hi = 0; seen_lo = 0; pp_bad = 0;
      for (int i = 0; i < 60; i++) begin
         if (pwm_drive_en[0] !== ~pwm_level[0]) bad++;
         if (pwm_level[0] === 1'b1) seen_hi++; else seen_lo++;
         if (pwm_drive_en[1] !== 1'b1) pp_bad++;
         @(negedge clk);
      end
      check_eq("R9 open-drain releases when high", bad, 0);
      check_eq("R9 open-drain saw both levels", int'(seen_hi > 0 && seen_lo > 0), 1);
      check_eq("R9 push-pull always drives", pp_bad, 0);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      t_reset();
      t_period();
      t_duty_edges();
      t_polarity();
      t_gating();
      t_select();
      t_source();
      t_enable();
      t_latch();
      t_open_drain();
      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

endmodule